// File: doc/BRIEF.md
# Operand Forwarding Select Unit

This block chooses where each ALU operand comes from at the start of the execute stage of a five-stage in-order pipeline. Each of the two execute sources can take the value read from the register file, the result waiting in the execute/memory latch, or the final value leaving writeback. The block also covers decode. A source read in decode can take the writeback value in place of the register file output when that register is being written in the same cycle.

The unit is purely combinational. It compares source indices with the destinations in the two later latches, qualified by their write flags. When both latches write the matching register, the younger producer wins, so a run of instructions that each rewrite one register always sees the newest result. A load that has only reached the memory stage has no data yet, so its result is never taken from the execute/memory latch. That case is left to the stall logic outside this block. The operand multiplexers are part of the block, so it produces finished operands as well as the selects.

Top module: `fwd_select`

## Requirements
- R1: When an execute source is nonzero, equals the execute/memory destination, that latch has its write flag set and it does not hold a load, the select is 2'b10 and the operand equals the execute/memory result.
- R2: When an execute source is nonzero, does not meet R1, and equals the memory/writeback destination with that write flag set, the select is 2'b01 and the operand equals the writeback value.
- R3: When both later latches write the register an execute source names, the execute/memory result is chosen (select 2'b10).
- R4: When no producer matches, the select is 2'b00 and the operand equals the register value presented for execute.
- R5: A latch whose write flag is low never causes a match, even if its destination equals the source.
- R6: Source index 0 is never forwarded. Its execute select is 2'b00, its decode bypass is 0, and its operand is zero.
- R7: A decode source takes the writeback value, with a bypass flag of 1, exactly when it is nonzero, equals the memory/writeback destination and that write flag is set. Otherwise the decode source passes the register file output with a flag of 0.
- R8: While the execute/memory latch holds a load, its result is never selected. The source falls through to the writeback match or to the register value.
- R9: Operands A and B are resolved independently by the same rules.
- R10: With stall-on-load-use supplied externally, a sequence of dependent instructions run through a pipeline using these operands leaves every architectural register equal to sequential execution.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ex_src_a | input | RIDX | Execute-stage source index A |
| ex_src_b | input | RIDX | Execute-stage source index B |
| ex_rval_a | input | XLEN | Register value carried into execute for A |
| ex_rval_b | input | XLEN | Register value carried into execute for B |
| em_dst | input | RIDX | Execute/memory latch destination |
| em_wen | input | 1 | Execute/memory latch register-write flag |
| em_load | input | 1 | Execute/memory latch holds a load |
| em_result | input | XLEN | Execute/memory latch ALU result |
| mw_dst | input | RIDX | Memory/writeback latch destination |
| mw_wen | input | 1 | Memory/writeback latch register-write flag |
| mw_value | input | XLEN | Final writeback value (ALU result or load data) |
| id_src_a | input | RIDX | Decode-stage source index A |
| id_src_b | input | RIDX | Decode-stage source index B |
| id_rf_a | input | XLEN | Register file read data A |
| id_rf_b | input | XLEN | Register file read data B |
| ex_sel_a | output | 2 | Execute select A: 00 register, 01 writeback, 10 execute/memory |
| ex_sel_b | output | 2 | Execute select B, same encoding |
| ex_opnd_a | output | XLEN | Resolved execute operand A |
| ex_opnd_b | output | XLEN | Resolved execute operand B |
| id_byp_a | output | 1 | Decode bypass A taken |
| id_byp_b | output | 1 | Decode bypass B taken |
| id_opnd_a | output | XLEN | Resolved decode operand A |
| id_opnd_b | output | XLEN | Resolved decode operand B |

## Verification
The assertions rely on the stall logic outside this block. They assume a consumer is never in execute while its producing load sits in the execute/memory latch, so a blocked memory-stage forward always has a correct fallback. The pipeline stimulus enforces this by inserting a one-cycle bubble whenever a load in execute writes a register the decode instruction reads. The free-running random vectors exercise R8 directly at the ports without that assumption. Register indices are drawn from a small range so that matches, double matches and index 0 occur often.

// File: rtl/fwd_select.sv
module fwd_select #(
  parameter int XLEN = 32,
  parameter int RIDX = 5
) (
  input  logic [RIDX-1:0] ex_src_a,
  input  logic [RIDX-1:0] ex_src_b,
  input  logic [XLEN-1:0] ex_rval_a,
  input  logic [XLEN-1:0] ex_rval_b,
  input  logic [RIDX-1:0] em_dst,
  input  logic            em_wen,
  input  logic            em_load,
  input  logic [XLEN-1:0] em_result,
  input  logic [RIDX-1:0] mw_dst,
  input  logic            mw_wen,
  input  logic [XLEN-1:0] mw_value,
  input  logic [RIDX-1:0] id_src_a,
  input  logic [RIDX-1:0] id_src_b,
  input  logic [XLEN-1:0] id_rf_a,
  input  logic [XLEN-1:0] id_rf_b,
  output logic [1:0]      ex_sel_a,
  output logic [1:0]      ex_sel_b,
  output logic [XLEN-1:0] ex_opnd_a,
  output logic [XLEN-1:0] ex_opnd_b,
  output logic            id_byp_a,
  output logic            id_byp_b,
  output logic [XLEN-1:0] id_opnd_a,
  output logic [XLEN-1:0] id_opnd_b
);
  localparam logic [1:0] SEL_RF = 2'b00;
  localparam logic [1:0] SEL_WB = 2'b01;
  localparam logic [1:0] SEL_EM = 2'b10;
  localparam logic [RIDX-1:0] R0 = '0;

  logic em_ok, mw_ok;
  assign em_ok = em_wen && !em_load && (em_dst != R0);
  assign mw_ok = mw_wen && (mw_dst != R0);

  assign ex_sel_a = (ex_src_a == R0)                 ? SEL_RF :
                    (em_ok && em_dst == ex_src_a)    ? SEL_EM :
                    (mw_ok && mw_dst == ex_src_a)    ? SEL_WB : SEL_RF;
  assign ex_sel_b = (ex_src_b == R0)                 ? SEL_RF :
                    (em_ok && em_dst == ex_src_b)    ? SEL_EM :
                    (mw_ok && mw_dst == ex_src_b)    ? SEL_WB : SEL_RF;

  always_comb begin
    unique case (ex_sel_a)
      SEL_EM:  ex_opnd_a = em_result;
      SEL_WB:  ex_opnd_a = mw_value;
      default: ex_opnd_a = (ex_src_a == R0) ? '0 : ex_rval_a;
    endcase
    unique case (ex_sel_b)
      SEL_EM:  ex_opnd_b = em_result;
      SEL_WB:  ex_opnd_b = mw_value;
      default: ex_opnd_b = (ex_src_b == R0) ? '0 : ex_rval_b;
    endcase
  end

  assign id_byp_a  = mw_ok && (mw_dst == id_src_a);
  assign id_byp_b  = mw_ok && (mw_dst == id_src_b);
  assign id_opnd_a = (id_src_a == R0) ? '0 : id_byp_a ? mw_value : id_rf_a;
  assign id_opnd_b = (id_src_b == R0) ? '0 : id_byp_b ? mw_value : id_rf_b;

  always_comb begin
    assert_sel_legal_R9: assert (ex_sel_a != 2'b11 && ex_sel_b != 2'b11)
      else $error("select code 11 produced");
    if (ex_src_a == R0)
      assert_zero_src_R6: assert (ex_opnd_a == '0 && id_byp_a == 1'b0 || id_src_a != R0 || ex_opnd_a == '0)
        else $error("index 0 operand nonzero");
    if (em_load)
      assert_no_load_fwd_R8: assert (ex_sel_a != SEL_EM && ex_sel_b != SEL_EM)
        else $error("load result forwarded from memory stage");
    if (ex_src_a != R0 && em_wen && !em_load && mw_wen && em_dst == ex_src_a && mw_dst == ex_src_a)
      assert_young_first_R3: assert (ex_opnd_a == em_result)
        else $error("older producer chosen");
    if (!mw_wen)
      assert_wen_gate_R5: assert (!id_byp_a && !id_byp_b && ex_sel_a != SEL_WB && ex_sel_b != SEL_WB)
        else $error("writeback match without write flag");
    if (id_byp_b)
      assert_id_bypass_R7: assert (id_opnd_b == mw_value)
        else $error("decode bypass value wrong");
  end
endmodule

// File: tb/test_fwd_select.sv
module test_fwd_select;
  localparam int XLEN = 32;
  localparam int RIDX = 5;
  localparam int NREG = 1 << RIDX;
  localparam int NPROG = 600;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic [RIDX-1:0] ex_src_a, ex_src_b, em_dst, mw_dst, id_src_a, id_src_b;
  logic [XLEN-1:0] ex_rval_a, ex_rval_b, em_result, mw_value, id_rf_a, id_rf_b;
  logic em_wen, em_load, mw_wen;
  logic [1:0] ex_sel_a, ex_sel_b;
  logic [XLEN-1:0] ex_opnd_a, ex_opnd_b, id_opnd_a, id_opnd_b;
  logic id_byp_a, id_byp_b;

  fwd_select #(.XLEN(XLEN), .RIDX(RIDX)) i_fwd_select (
    .ex_src_a(ex_src_a), .ex_src_b(ex_src_b), .ex_rval_a(ex_rval_a), .ex_rval_b(ex_rval_b),
    .em_dst(em_dst), .em_wen(em_wen), .em_load(em_load), .em_result(em_result),
    .mw_dst(mw_dst), .mw_wen(mw_wen), .mw_value(mw_value),
    .id_src_a(id_src_a), .id_src_b(id_src_b), .id_rf_a(id_rf_a), .id_rf_b(id_rf_b),
    .ex_sel_a(ex_sel_a), .ex_sel_b(ex_sel_b), .ex_opnd_a(ex_opnd_a), .ex_opnd_b(ex_opnd_b),
    .id_byp_a(id_byp_a), .id_byp_b(id_byp_b), .id_opnd_a(id_opnd_a), .id_opnd_b(id_opnd_b));

  int n_chk = 0;
  int n_bad = 0;

  task automatic check(input string tag, input logic [XLEN-1:0] act, input logic [XLEN-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [1:0] exp_sel(input logic [RIDX-1:0] s);
    if (s == 0) return 2'b00;
    if (em_wen && !em_load && em_dst == s) return 2'b10;
    if (mw_wen && mw_dst == s) return 2'b01;
    return 2'b00;
  endfunction

  function automatic logic [XLEN-1:0] exp_opnd(input logic [RIDX-1:0] s, input logic [XLEN-1:0] rv);
    logic [1:0] k = exp_sel(s);
    if (k == 2'b10) return em_result;
    if (k == 2'b01) return mw_value;
    return (s == 0) ? '0 : rv;
  endfunction

  function automatic logic exp_byp(input logic [RIDX-1:0] s);
    return s != 0 && mw_wen && mw_dst == s;
  endfunction

  task automatic check_all(input string tag);
    #1;
    check({tag, " selA"}, XLEN'(ex_sel_a), XLEN'(exp_sel(ex_src_a)));
    check({tag, " selB R9"}, XLEN'(ex_sel_b), XLEN'(exp_sel(ex_src_b)));
    check({tag, " opA"}, ex_opnd_a, exp_opnd(ex_src_a, ex_rval_a));
    check({tag, " opB R9"}, ex_opnd_b, exp_opnd(ex_src_b, ex_rval_b));
    check({tag, " R7 bypA"}, XLEN'(id_byp_a), XLEN'(exp_byp(id_src_a)));
    check({tag, " R7 bypB"}, XLEN'(id_byp_b), XLEN'(exp_byp(id_src_b)));
    check({tag, " R7 idA"}, id_opnd_a, id_src_a == 0 ? '0 : exp_byp(id_src_a) ? mw_value : id_rf_a);
    check({tag, " R7 idB"}, id_opnd_b, id_src_b == 0 ? '0 : exp_byp(id_src_b) ? mw_value : id_rf_b);
  endtask

  task automatic drive_idle();
    ex_src_a = 0; ex_src_b = 0; ex_rval_a = 0; ex_rval_b = 0;
    em_dst = 0; em_wen = 0; em_load = 0; em_result = 0;
    mw_dst = 0; mw_wen = 0; mw_value = 0;
    id_src_a = 0; id_src_b = 0; id_rf_a = 0; id_rf_b = 0;
  endtask

  typedef struct packed {
    logic [1:0]      op;
    logic [RIDX-1:0] d;
    logic [RIDX-1:0] a;
    logic [RIDX-1:0] b;
    logic [15:0]     imm;
  } ins_t;
  localparam logic [1:0] OP_ADD = 2'd0, OP_XOR = 2'd1, OP_LD = 2'd2, OP_NOP = 2'd3;

  ins_t prog [NPROG];
  logic [XLEN-1:0] rf [NREG];
  logic [XLEN-1:0] ref_rf [NREG];

  function automatic logic [XLEN-1:0] ld_data(input logic [XLEN-1:0] addr);
    return {addr[15:0] ^ 16'hA5C3, addr[15:0] + 16'h1357};
  endfunction

  function automatic logic [XLEN-1:0] alu(input ins_t i, input logic [XLEN-1:0] a, input logic [XLEN-1:0] b);
    case (i.op)
      OP_ADD:  return a + b + XLEN'(i.imm);
      OP_XOR:  return a ^ b ^ XLEN'(i.imm);
      default: return a + XLEN'(i.imm);
    endcase
  endfunction

  task automatic run_program();
    ins_t nop_i = '{op: OP_NOP, d: '0, a: '0, b: '0, imm: '0};
    ins_t ex_i = nop_i, em_i = nop_i, mw_i = nop_i, id_i;
    logic [XLEN-1:0] ex_ra = 0, ex_rb = 0, em_res = 0, mw_val = 0, res;
    int pc = 0;
    int drain = 0;
    for (int r = 0; r < NREG; r++) begin rf[r] = XLEN'(r * 32'h0101); ref_rf[r] = rf[r]; end
    rf[0] = 0; ref_rf[0] = 0;
    for (int k = 0; k < NPROG; k++) begin
      logic [XLEN-1:0] va = ref_rf[prog[k].a], vb = ref_rf[prog[k].b], v;
      v = alu(prog[k], va, vb);
      if (prog[k].op == OP_LD) v = ld_data(v);
      if (prog[k].op != OP_NOP && prog[k].d != 0) ref_rf[prog[k].d] = v;
    end
    while (drain < 4) begin
      logic stall;
      @(negedge clk);
      id_i = (pc < NPROG) ? prog[pc] : nop_i;
      id_src_a = id_i.a; id_src_b = id_i.b;
      id_rf_a = rf[id_i.a]; id_rf_b = rf[id_i.b];
      ex_src_a = ex_i.a; ex_src_b = ex_i.b; ex_rval_a = ex_ra; ex_rval_b = ex_rb;
      em_dst = em_i.d; em_wen = em_i.op != OP_NOP; em_load = em_i.op == OP_LD; em_result = em_res;
      mw_dst = mw_i.d; mw_wen = mw_i.op != OP_NOP; mw_value = mw_val;
      #1;
      res = alu(ex_i, ex_opnd_a, ex_opnd_b);
      if (mw_i.op != OP_NOP && mw_i.d != 0) rf[mw_i.d] = mw_val;
      mw_val = (em_i.op == OP_LD) ? ld_data(em_res) : em_res;
      mw_i = em_i;
      em_res = res;
      em_i = ex_i;
      stall = ex_i.op == OP_LD && ex_i.d != 0 && (id_i.a == ex_i.d || id_i.b == ex_i.d);
      if (stall) begin
        ex_i = nop_i; ex_ra = 0; ex_rb = 0;
      end else begin
        ex_i = id_i; ex_ra = id_opnd_a; ex_rb = id_opnd_b;
        if (pc < NPROG) pc++; else drain++;
      end
    end
    for (int r = 1; r < NREG; r++)
      check($sformatf("R10 R1 R2 R3 R7 reg %0d", r), rf[r], ref_rf[r]);
  endtask

  initial begin
    #(4 * 200000);
    n_bad++;
    $display("FAIL watchdog: actual running expected finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    drive_idle();
    @(negedge clk);
    check_all("R4 idle");
    check("R4 idle sel", XLEN'(ex_sel_a), 0);

    // R1 memory-stage forward
    drive_idle(); ex_src_a = 5; ex_rval_a = 32'h11; em_dst = 5; em_wen = 1; em_result = 32'hE0E0;
    check_all("R1");
    check("R1 direct", ex_opnd_a, 32'hE0E0);
    // R2 writeback forward
    drive_idle(); ex_src_b = 6; ex_rval_b = 32'h22; mw_dst = 6; mw_wen = 1; mw_value = 32'hBEEF;
    check_all("R2");
    check("R2 direct", ex_opnd_b, 32'hBEEF);
    // R3 both latches write the same register
    drive_idle(); ex_src_a = 3; ex_src_b = 3; em_dst = 3; em_wen = 1; em_result = 32'hAAAA;
    mw_dst = 3; mw_wen = 1; mw_value = 32'hBBBB;
    check_all("R3");
    check("R3 direct", XLEN'(ex_sel_a), 32'd2);
    // R5 write flags low
    drive_idle(); ex_src_a = 4; ex_rval_a = 32'h44; em_dst = 4; mw_dst = 4; id_src_a = 4; id_rf_a = 32'h77;
    em_result = 32'h1; mw_value = 32'h2;
    check_all("R5");
    check("R5 direct", ex_opnd_a, 32'h44);
    check("R5 decode", id_opnd_a, 32'h77);
    // R6 index zero
    drive_idle(); ex_rval_a = 32'hFFFF; em_wen = 1; mw_wen = 1; em_result = 9; mw_value = 8; id_rf_a = 32'h5;
    check_all("R6");
    check("R6 direct", ex_opnd_a, 0);
    check("R6 decode", id_opnd_a, 0);
    // R8 load in memory stage falls through to writeback
    drive_idle(); ex_src_a = 7; ex_rval_a = 32'h70; em_dst = 7; em_wen = 1; em_load = 1; em_result = 32'hDEAD;
    mw_dst = 7; mw_wen = 1; mw_value = 32'h1234;
    check_all("R8");
    check("R8 direct", ex_opnd_a, 32'h1234);

    for (int k = 0; k < 3000; k++) begin
      @(negedge clk);
      ex_src_a = RIDX'($urandom_range(0, 4)); ex_src_b = RIDX'($urandom_range(0, 4));
      id_src_a = RIDX'($urandom_range(0, 4)); id_src_b = RIDX'($urandom_range(0, 4));
      em_dst = RIDX'($urandom_range(0, 4)); mw_dst = RIDX'($urandom_range(0, 4));
      em_wen = 1'($urandom); mw_wen = 1'($urandom); em_load = ($urandom_range(0, 3) == 0);
      ex_rval_a = $urandom; ex_rval_b = $urandom; em_result = $urandom; mw_value = $urandom;
      id_rf_a = $urandom; id_rf_b = $urandom;
      check_all("R1 R2 R3 R4 R5 R6 R8 random");
    end

    for (int k = 0; k < NPROG; k++) begin
      prog[k].op  = 2'($urandom_range(0, 3));
      prog[k].d   = RIDX'($urandom_range(0, 5));
      prog[k].a   = RIDX'($urandom_range(0, 5));
      prog[k].b   = RIDX'($urandom_range(0, 5));
      prog[k].imm = 16'($urandom);
    end
    run_program();

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule